// File: doc/BRIEF.md
# Programmable Interval Timer, 14-bit

This block is a binary down-counting interval timer with one output pin. The host writes a start value N through two byte registers. The low register holds count bits 7:0. The high register holds count bits 13:8 in its low six bits and a 2-bit waveform selector in bits 7:6. A 2-bit command then starts the timer, stops it or lets it finish. The timer steps once for each count-clock enable pulse (`cnt_tick`). That pulse comes from the timer clock after it has been brought into the `clk` domain.

There are four waveform selections. Square-wave output can run for one period or repeat. Terminal-count pulse output, one tick low, can also run once or repeat. A terminal-count flag records each expiry and stays set until the host reads it. Bus decoding and the storage around the timer are outside this block. It sees only byte-write strobes, a command strobe and a flag-read strobe.

Top module: `itimer14`

## Requirements
- R1: After a synchronous active-low reset the timer is idle (`busy`=0), `tmr_out` is 1, `tc_flag` is 0 and both byte registers hold 0.
- R2: Command 11 (start) applied while idle with N = {hi[5:0], lo} >= 2 latches N and the selector hi[7:6], and `busy` is 1 on the following cycle. The timer then advances one step per cycle in which `cnt_tick` is 1, with a period of N ticks.
- R3: A start command whose N is 0 or 1 leaves the timer idle with `tmr_out` at 1.
- R4: In selectors 00 and 01 (square wave), each period drives `tmr_out` high for the first ceil(N/2) ticks and low for the remaining floor(N/2) ticks.
- R5: Selector 00 runs one square-wave period and then returns to idle with `tmr_out` high.
- R6: Selector 01 reloads N at each terminal count and repeats the square wave without a gap.
- R7: Selector 10 holds `tmr_out` high and drives it low for exactly the last tick interval of the period. It then returns to idle with `tmr_out` high.
- R8: Selector 11 repeats the selector 10 low pulse once every N ticks.
- R9: Command 01 stops the timer on the next cycle, whatever the phase, and returns `tmr_out` to 1.
- R10: Command 10 issued while running lets the current period complete. The timer goes idle at the next terminal count instead of reloading.
- R11: `tc_flag` is set at every terminal count and is cleared by `tc_read`. If both happen in the same cycle, the flag stays set.
- R12: While the timer is running, a start command and new byte-register writes do not change the running period or selector.
- R13: Ticks applied while idle and command 00 at any time have no effect on `busy` or `tmr_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_lo | input | 1 | Write strobe for the low count byte |
| wr_hi | input | 1 | Write strobe for the high byte (count bits and waveform selector) |
| wr_data | input | 8 | Byte written by either strobe |
| cmd_valid | input | 1 | Qualifies `cmd` for one cycle |
| cmd | input | 2 | 00 none, 01 stop now, 10 stop at terminal count, 11 start |
| cnt_tick | input | 1 | One-cycle count-clock enable pulse |
| tc_read | input | 1 | Host read of the terminal-count flag (clears it) |
| tmr_out | output | 1 | Timer output pin |
| tc_flag | output | 1 | Terminal-count flag |
| busy | output | 1 | Timer is counting |

## Verification
A wrong count or reload value shows up on `tmr_out`. The high or low half ends on the wrong tick, or the pulse appears a tick early or late, within one period of the start. An illegal N that is loaded anyway shows up as `busy` rising on the cycle after the start command. A stop or stop-pending bit that is never cleared shows up as a missing second period or as a timer that will not restart. A selector latched at the wrong moment changes the waveform shape within the first half-period. A lost terminal-count event shows up on `tc_flag` on the cycle after the expiring tick.

// File: rtl/itimer14_pkg.sv
// Shared encodings for the interval timer.
// Assumes: the selector and command fields are 2 bits wide.
package itimer14_pkg;

    typedef enum logic [1:0] {
        WAVE_SQ_ONCE = 2'b00,
        WAVE_SQ_LOOP = 2'b01,
        WAVE_PL_ONCE = 2'b10,
        WAVE_PL_LOOP = 2'b11
    } wave_sel_e;

    typedef enum logic [1:0] {
        TCMD_NONE     = 2'b00,
        TCMD_HALT     = 2'b01,
        TCMD_HALT_TC  = 2'b10,
        TCMD_GO       = 2'b11
    } tmr_cmd_e;

    function automatic logic sel_is_square(input wave_sel_e s);
        return (s == WAVE_SQ_ONCE) || (s == WAVE_SQ_LOOP);
    endfunction

    function automatic logic sel_is_once(input wave_sel_e s);
        return (s == WAVE_SQ_ONCE) || (s == WAVE_PL_ONCE);
    endfunction

endpackage

// File: rtl/itimer14_loadregs.sv
// Host-writable byte registers holding the next start value and selector.
// Assumes: CNT_W lies between 9 and 14. The high byte carries count bits
// in its low part and the selector in bits 7:6. Bits in between are dropped.
module itimer14_loadregs
    import itimer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [7:0]       wr_data,
    output logic [CNT_W-1:0] next_count,
    output wave_sel_e        next_sel
);
    localparam int HI_W = CNT_W - 8;

    logic [7:0]      lo_q;
    logic [HI_W-1:0] hi_cnt_q;
    logic [1:0]      sel_q;

    // Capture each byte on its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q     <= '0;
            hi_cnt_q <= '0;
            sel_q    <= '0;
        end else begin
            if (wr_lo) lo_q <= wr_data;
            if (wr_hi) begin
                hi_cnt_q <= wr_data[HI_W-1:0];
                sel_q    <= wr_data[7:6];
            end
        end
    end

    // Present the assembled value to the control logic.
    always_comb begin
        next_count = {hi_cnt_q, lo_q};
        next_sel   = wave_sel_e'(sel_q);
    end
endmodule

// File: rtl/itimer14_ctrl.sv
// Run control: decodes host commands, latches the period and selector on
// a legal start, and decides when the timer returns to idle.
// Assumes: the command strobe lasts one cycle. A stop-now command wins
// over a tick in the same cycle.
module itimer14_ctrl
    import itimer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] next_count,
    input  wave_sel_e        next_sel,
    input  logic             tc_evt,
    output logic             running,
    output logic             load,
    output logic             advance,
    output logic [CNT_W-1:0] period,
    output wave_sel_e        sel
);
    localparam logic [CNT_W-1:0] MIN_N = CNT_W'(2);

    logic     halt_now;
    logic     halt_tc_req;
    logic     stop_pend;
    logic     end_at_tc;
    tmr_cmd_e cmd_e;

    // Decode the command strobe and form the per-cycle controls.
    always_comb begin
        cmd_e       = tmr_cmd_e'(cmd);
        halt_now    = cmd_valid && (cmd_e == TCMD_HALT);
        halt_tc_req = cmd_valid && (cmd_e == TCMD_HALT_TC) && running;
        load        = cmd_valid && (cmd_e == TCMD_GO) && !running
                      && (next_count >= MIN_N);
        advance     = running && cnt_tick && !halt_now;
        end_at_tc   = tc_evt && (sel_is_once(sel) || stop_pend);
    end

    // Run state and pending-stop bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
        end else if (load) begin
            running   <= 1'b1;
            stop_pend <= 1'b0;
        end else if (halt_now || end_at_tc) begin
            running   <= 1'b0;
            stop_pend <= 1'b0;
        end else if (halt_tc_req) begin
            stop_pend <= 1'b1;
        end
    end

    // Latch period and selector only on a legal start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            sel    <= WAVE_SQ_ONCE;
        end else if (load) begin
            period <= next_count;
            sel    <= next_sel;
        end
    end

    a_r3_short_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 2'b11 && !running && next_count < MIN_N) |=> !running);

    a_r9_halt_now: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd == 2'b01) |=> !running);

    a_r5_once_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && sel_is_once(sel)) |=> !running);

    a_r12_period_held: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> ($stable(period) && $stable(sel)));

    a_r6_loop_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_evt && !sel_is_once(sel) && !stop_pend && !halt_now) |=> running);
endmodule

// File: rtl/itimer14_counter.sv
// Binary down-counter: loads the period on start, steps on each advance,
// and reloads at terminal count (value 1 stepping away).
// Assumes: advance is only raised while the timer runs.
module itimer14_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             running,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] next_count,
    output logic [CNT_W-1:0] cnt,
    output logic             tc_evt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Terminal count is the tick that leaves value 1.
    always_comb tc_evt = advance && (cnt == ONE);

    // Count register: load, reload or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= next_count;
        else if (tc_evt)  cnt <= period;
        else if (advance) cnt <= cnt - ONE;
    end

    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (cnt != '0 && cnt <= period));

    a_r2_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !tc_evt) |=> (cnt == $past(cnt) - ONE));
endmodule

// File: rtl/itimer14_wave.sv
// Output shaper: square wave (high while the count is above half the
// period) or a one-tick low pulse while the count sits at 1.
// Assumes: the output rests high when the timer is idle.
module itimer14_wave
    import itimer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic             running,
    input  wave_sel_e        sel,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] period,
    output logic             wave
);
    logic [CNT_W-1:0] half;

    // Choose the output level from the count phase.
    always_comb begin
        half = period >> 1;
        if (!running)               wave = 1'b1;
        else if (sel_is_square(sel)) wave = (cnt > half);
        else                         wave = (cnt != CNT_W'(1));
    end
endmodule

// File: rtl/itimer14.sv
// Top level of the 14-bit interval timer. It ties together the load
// registers, run control, down-counter and output shaper, and holds the
// terminal-count flag.
// Assumes: cnt_tick is already synchronous to clk.
module itimer14
    import itimer14_pkg::*;
#(
    parameter int CNT_W = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_lo,
    input  logic       wr_hi,
    input  logic [7:0] wr_data,
    input  logic       cmd_valid,
    input  logic [1:0] cmd,
    input  logic       cnt_tick,
    input  logic       tc_read,
    output logic       tmr_out,
    output logic       tc_flag,
    output logic       busy
);
    logic [CNT_W-1:0] next_count;
    wave_sel_e        next_sel;
    logic             running;
    logic             load;
    logic             advance;
    logic [CNT_W-1:0] period;
    wave_sel_e        sel;
    logic [CNT_W-1:0] cnt;
    logic             tc_evt;

    itimer14_loadregs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .next_count(next_count), .next_sel(next_sel)
    );

    itimer14_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd(cmd),
        .cnt_tick(cnt_tick), .next_count(next_count), .next_sel(next_sel),
        .tc_evt(tc_evt), .running(running), .load(load), .advance(advance),
        .period(period), .sel(sel)
    );

    itimer14_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .running(running), .period(period), .next_count(next_count),
        .cnt(cnt), .tc_evt(tc_evt)
    );

    itimer14_wave #(.CNT_W(CNT_W)) u_wave (
        .running(running), .sel(sel), .cnt(cnt), .period(period),
        .wave(tmr_out)
    );

    // Terminal-count flag: a new expiry wins over a host read.
    always_ff @(posedge clk) begin
        if (!rst_n)       tc_flag <= 1'b0;
        else if (tc_evt)  tc_flag <= 1'b1;
        else if (tc_read) tc_flag <= 1'b0;
    end

    always_comb busy = running;

    a_r11_flag_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> tc_flag);

    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_read && !tc_evt) |=> !tc_flag);

    a_r13_idle_tick_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(cmd_valid && cmd == 2'b11)) |=> (!busy && tmr_out));
endmodule

// File: tb/itimer14_bench.sv
`timescale 1ns/1ps
module itimer14_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0] wr_data = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd = '0;
    logic       cnt_tick = 1'b0;
    logic       tc_read = 1'b0;
    logic       tmr_out, tc_flag, busy;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    itimer14 u_itimer14 (
        .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .cmd_valid(cmd_valid), .cmd(cmd),
        .cnt_tick(cnt_tick), .tc_read(tc_read), .tmr_out(tmr_out),
        .tc_flag(tc_flag), .busy(busy)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Each task drives at a falling edge; the next falling edge sees the result.
    task automatic write_n(input int n, input int sel);
        @(negedge clk); wr_lo = 1'b1; wr_data = n[7:0];
        @(negedge clk); wr_lo = 1'b0; wr_hi = 1'b1;
        wr_data = {sel[1:0], n[13:8]};
        @(negedge clk); wr_hi = 1'b0;
    endtask

    task automatic send(input logic [1:0] c);
        @(negedge clk); cmd_valid = 1'b1; cmd = c;
        @(negedge clk); cmd_valid = 1'b0; cmd = 2'b00;
    endtask

    task automatic tick(input logic rd);
        @(negedge clk); cnt_tick = 1'b1; tc_read = rd;
        @(negedge clk); cnt_tick = 1'b0; tc_read = 1'b0;
    endtask

    task automatic read_flag();
        @(negedge clk); tc_read = 1'b1;
        @(negedge clk); tc_read = 1'b0;
    endtask

    function automatic int exp_wave(input int sel, input int n, input int t);
        int r;
        int c;
        r = t % n;
        c = n - r;
        if (sel < 2) return (c > n / 2) ? 1 : 0;
        return (c != 1) ? 1 : 0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int highs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 out", tmr_out, 1);
        check("R1 flag", tc_flag, 0);
        send(2'b11);   // registers hold 0 -> illegal start
        check("R1 regs zero (start refused)", busy, 0);

        // Sweep: every selector, N = 0..17
        for (int sel = 0; sel < 4; sel++) begin
            for (int n = 0; n < 18; n++) begin
                int tmax;
                bit once;
                once = (sel == 0) || (sel == 2);
                send(2'b01);
                read_flag();
                write_n(n, sel);
                send(2'b11);
                if (n < 2) begin
                    check("R3 short count idle", busy, 0);
                    check("R3 short count out", tmr_out, 1);
                    tick(1'b0);
                    check("R13 idle tick", busy, 0);
                    continue;
                end
                check("R2 start busy", busy, 1);
                check("R4 R7 initial level", tmr_out, 1);
                tmax = once ? n + 2 : 2 * n + 1;
                for (int t = 1; t <= tmax; t++) begin
                    int er;
                    int eo;
                    tick(1'b0);
                    er = once ? (t < n) : 1;
                    eo = er ? exp_wave(sel, n, t) : 1;
                    if (sel < 2)
                        check(once ? "R4 R5 square once" : "R4 R6 square loop", tmr_out, eo);
                    else
                        check(once ? "R7 pulse once" : "R8 pulse loop", tmr_out, eo);
                    check(once ? "R5 R7 run state" : "R6 R8 run state", busy, er);
                    if (t == n - 1) check("R11 flag before tc", tc_flag, 0);
                    if (t == n)     check("R11 flag at tc", tc_flag, 1);
                end
            end
        end

        // R11: read clears; read on the expiring tick loses to the set
        send(2'b01); read_flag();
        write_n(3, 1); send(2'b11);
        tick(1'b0); tick(1'b0); tick(1'b0);
        check("R11 set", tc_flag, 1);
        read_flag();
        check("R11 read clears", tc_flag, 0);
        tick(1'b0); tick(1'b0); tick(1'b1);
        check("R11 set wins over read", tc_flag, 1);

        // R9: stop now mid-low-phase
        send(2'b01); read_flag();
        write_n(10, 1); send(2'b11);
        repeat (7) tick(1'b0);
        check("R9 low before stop", tmr_out, 0);
        send(2'b01);
        check("R9 stopped", busy, 0);
        check("R9 out high", tmr_out, 1);
        repeat (4) tick(1'b0);
        check("R13 ticks after stop", busy, 0);

        // R10: stop at terminal count in loop mode
        write_n(6, 1); send(2'b11);
        tick(1'b0); tick(1'b0);
        send(2'b10);
        tick(1'b0); tick(1'b0); tick(1'b0);
        check("R10 still running", busy, 1);
        check("R10 low half", tmr_out, 0);
        tick(1'b0);
        check("R10 idle at tc", busy, 0);
        check("R10 out high", tmr_out, 1);
        send(2'b11);
        check("R10 restart possible", busy, 1);

        // R12 + R13: busy timer ignores start and new bytes; cmd 00 inert
        send(2'b01);
        write_n(5, 1); send(2'b11);
        write_n(9, 0);
        send(2'b11);
        send(2'b00);
        repeat (5) tick(1'b0);   // one full period of 5
        check("R12 loop kept", busy, 1);
        repeat (3) tick(1'b0);   // count 2 of 5 -> low; 6 of 9 would be high
        check("R12 period kept", tmr_out, 0);
        check("R13 cmd none", busy, 1);

        // R4: largest count, one full period measured
        send(2'b01);
        write_n(16383, 1); send(2'b11);
        highs = 0;
        for (int t = 0; t < 16383; t++) begin
            if (t > 0) tick(1'b0);
            highs += tmr_out;
        end
        check("R4 high ticks at max N", highs, 8192);
        tick(1'b0);
        check("R6 reload at max N", tmr_out, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule